// File: doc/BRIEF.md
# Latched Interrupt Collector with Clear-and-Mask Register

This block gathers a group of status event sources into one latched, active-low interrupt request for a host processor. Two kinds of source feed it. The first is a vector of performance status bits, where any change of a bit counts as an event. The second is a pair of elastic store level flags, one for overflow and one for underflow. Each source has its own request latch and its own bit in a host-writable clear register.

The clear register serves two purposes. Writing 1 to a bit acknowledges that source: its latch empties on the first clock where the cause is no longer present. While the 1 stays in the register, the source is also masked. Writing 0 enables the source again. The host writes the whole register at once through a write strobe and a data word. It can read the latch vector directly to see which sources are pending.

The latch vector is ordered with the status-change sources in bits `NSTAT-1:0`, overflow in bit `NSTAT` and underflow in bit `NSTAT+1`. The clear register uses the same bit order.

Top module: `irq_clrmask_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, every latch is empty (`pend_o` = 0), `irq_n_o` is 1 and every clear-register bit is 0, so every source is enabled.
- R2: A status source sets latch bit i at a clock edge where `stat_i[i]` differs from the value sampled at the previous edge and the clear bit i is 0.
- R3: Overflow (latch bit `NSTAT`) and underflow (latch bit `NSTAT+1`) are level sources. Each sets its own latch at any edge where its input is 1 and its clear bit is 0.
- R4: `irq_n_o` is 0 in the cycle after an edge at which some latch bit is 1 and its clear bit is 0. Otherwise it is 1.
- R5: A pulse on `clr_we_i` loads the whole clear register from `clr_wdata_i`. A source whose clear bit is 1 never sets its latch, and its latch does not drive `irq_n_o` low.
- R6: A latch bit empties at an edge where its clear bit is 1, or is being written 1, and its cause is absent. While the cause is present, the bit stays set.
- R7: After its clear bit is written back to 0, a source can set its latch again.
- R8: If an enabled source has an event in the same cycle that a 1 is written to its clear bit, the latch is set at that edge. It empties only at a later edge.
- R9: The first edge after reset only samples `stat_i`. A status value already present during reset is not treated as a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | NSTAT | Performance status bits; any change is an event |
| es_over_i | input | 1 | Elastic store overflow level |
| es_under_i | input | 1 | Elastic store underflow level |
| clr_we_i | input | 1 | Write strobe for the clear register |
| clr_wdata_i | input | NSTAT+2 | New clear-register contents |
| pend_o | output | NSTAT+2 | Latch status vector |
| irq_n_o | output | 1 | Latched interrupt request, active low |

## Verification
The bench writes the clear register while the overflow level is still high. A design that empties the latch early would let `pend_o` fall before the level drops. It also lines up a status change with a clear write on the same source, a case where a design that gives the clear priority would lose the event. Other scenarios check that a masked source neither latches nor pulls the interrupt low, and that writing 0 makes the source fire again. A status value held through reset must not count as a change; a design that compares against a reset value of zero would raise a false request on the first edge.

// File: rtl/irqcm_pkg.sv
package irqcm_pkg;

  // Next state of one request latch: an enabled event sets it; a clear
  // request empties it only when the cause is absent; otherwise it holds.
  function automatic logic latch_next(input logic cur, input logic ev,
                                      input logic en, input logic clr);
    if (ev && en)       return 1'b1;
    else if (clr && !ev) return 1'b0;
    else                return cur;
  endfunction

  // Active-low request from latches gated by their enables.
  function automatic logic req_low(input logic [63:0] pend,
                                   input logic [63:0] mask);
    return ~|(pend & ~mask);
  endfunction

endpackage

// File: rtl/irqcm_chg_det.sv
module irqcm_chg_det #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= stat_i;
      primed_q <= 1'b1;
    end
  end

  assign chg_o = primed_q ? (stat_i ^ prev_q) : '0;
endmodule

// File: rtl/irqcm_mask_reg.sv
module irqcm_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irqcm_src_latch.sv
module irqcm_src_latch
  import irqcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= latch_next(pend_o, ev_i, en_i, clr_i);
  end
endmodule

// File: rtl/irq_clrmask_ctl.sv
module irq_clrmask_ctl
  import irqcm_pkg::*;
#(
  parameter int NSTAT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTAT-1:0]     stat_i,
  input  logic                 es_over_i,
  input  logic                 es_under_i,
  input  logic                 clr_we_i,
  input  logic [NSTAT+1:0]     clr_wdata_i,
  output logic [NSTAT+1:0]     pend_o,
  output logic                 irq_n_o
);
  localparam int NSRC   = NSTAT + 2;
  localparam int OV_IDX = NSTAT;
  localparam int UN_IDX = NSTAT + 1;

  logic [NSTAT-1:0] chg_w;
  logic [NSRC-1:0]  ev_w;
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  clr_eff_w;
  logic [63:0]      pend_ext_w;
  logic [63:0]      mask_ext_w;

  irqcm_chg_det #(.W(NSTAT)) u_chg (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .chg_o(chg_w)
  );

  irqcm_mask_reg #(.W(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(clr_we_i), .wdata_i(clr_wdata_i),
    .mask_o(mask_q)
  );

  always_comb begin
    ev_w = '0;
    ev_w[NSTAT-1:0] = chg_w;
    ev_w[OV_IDX]    = es_over_i;
    ev_w[UN_IDX]    = es_under_i;
  end

  assign clr_eff_w = mask_q | (clr_wdata_i & {NSRC{clr_we_i}});

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irqcm_src_latch u_lat (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_w[i]), .en_i(~mask_q[i]),
      .clr_i(clr_eff_w[i]), .pend_o(pend_o[i])
    );
  end

  always_comb begin
    pend_ext_w = '0;
    mask_ext_w = '0;
    pend_ext_w[NSRC-1:0] = pend_o;
    mask_ext_w[NSRC-1:0] = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= req_low(pend_ext_w, mask_ext_w);
  end
endmodule

// File: rtl/irq_clrmask_ctl_chk.sv
module irq_clrmask_ctl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_we_i,
  input logic [NSRC-1:0] clr_wdata_i,
  input logic [NSRC-1:0] pend_o,
  input logic            irq_n_o,
  input logic [NSRC-1:0] ev_w,
  input logic [NSRC-1:0] mask_q
);
  // R4
  irq_low_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> ($past(pend_o & ~mask_q) != '0));

  // R5
  masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((pend_o & ~$past(pend_o) & $past(mask_q)) == '0));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> (mask_q == $past(clr_wdata_i)));

  // R6
  clear_needs_cause_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((~pend_o & $past(pend_o) &
               ($past(ev_w) | ~($past(mask_q) |
                 ($past(clr_wdata_i) & {NSRC{$past(clr_we_i)}})))) == '0));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_w & ~mask_q) != '0) |=>
      ((pend_o & $past(ev_w & ~mask_q)) == $past(ev_w & ~mask_q)));
endmodule

bind irq_clrmask_ctl irq_clrmask_ctl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
  .pend_o(pend_o), .irq_n_o(irq_n_o), .ev_w(ev_w), .mask_q(mask_q)
);

// File: tb/irq_clrmask_ctl_test.sv
module irq_clrmask_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSTAT = 6;
  localparam int NSRC  = NSTAT + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSTAT-1:0] stat_i = '0;
  logic             es_over_i = 1'b0;
  logic             es_under_i = 1'b0;
  logic             clr_we_i = 1'b0;
  logic [NSRC-1:0]  clr_wdata_i = '0;
  logic [NSRC-1:0]  pend_o;
  logic             irq_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [NSRC-1:0] pend;
    logic            irq_n;
    int              req;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_clrmask_ctl #(.NSTAT(NSTAT)) uut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .es_over_i(es_over_i),
    .es_under_i(es_under_i), .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
    .pend_o(pend_o), .irq_n_o(irq_n_o)
  );

  task automatic cmp(input logic [NSRC-1:0] ap, input logic ai,
                     input logic [NSRC-1:0] ep, input logic ei, input int r);
    checks++;
    if (ap !== ep) begin
      fails++;
      $display("FAIL R%0d pend_o actual=%h expected=%h", r, ap, ep);
    end
    checks++;
    if (ai !== ei) begin
      fails++;
      $display("FAIL R%0d irq_n_o actual=%b expected=%b", r, ai, ei);
    end
  endtask

  // driver: apply inputs for one edge and push what must be seen after it
  task automatic step(input logic [NSTAT-1:0] st, input logic ov, input logic un,
                      input logic we, input logic [NSRC-1:0] wd,
                      input logic [NSRC-1:0] ep, input logic ei, input int r);
    exp_t e;
    @(negedge clk);
    stat_i = st; es_over_i = ov; es_under_i = un;
    clr_we_i = we; clr_wdata_i = wd;
    e.pend = ep; e.irq_n = ei; e.req = r;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(pend_o, irq_n_o, e.pend, e.irq_n, e.req);
      end
    end
  end

  initial begin
    stat_i = 6'h05;
    repeat (3) @(posedge clk);
    #1;
    cmp(pend_o, irq_n_o, '0, 1'b1, 1); // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;
    step(6'h05, 0, 0, 0, 8'h00, 8'h00, 1, 9); // R9 first edge only samples
    step(6'h05, 0, 0, 0, 8'h00, 8'h00, 1, 1); // R1 idle after reset
    step(6'h07, 0, 0, 0, 8'h00, 8'h02, 1, 2); // R2 bit1 change
    step(6'h07, 0, 0, 0, 8'h00, 8'h02, 0, 4); // R4 irq low next cycle
    step(6'h07, 0, 0, 1, 8'h02, 8'h00, 0, 6); // R6 clear, cause gone
    step(6'h07, 0, 0, 0, 8'h00, 8'h00, 1, 4); // R4 released
    step(6'h05, 0, 0, 0, 8'h00, 8'h00, 1, 5); // R5 masked change ignored
    step(6'h05, 1, 0, 0, 8'h00, 8'h40, 1, 3); // R3 overflow level
    step(6'h05, 1, 0, 1, 8'h42, 8'h40, 0, 6); // R6 held while cause present
    step(6'h05, 1, 0, 0, 8'h00, 8'h40, 1, 5); // R5 masked latch no irq
    step(6'h05, 0, 0, 0, 8'h00, 8'h00, 1, 6); // R6 empties once level drops
    step(6'h05, 0, 0, 1, 8'h00, 8'h00, 1, 7); // R7 re-enable write
    step(6'h05, 0, 1, 0, 8'h00, 8'h80, 1, 3); // R3 underflow level
    step(6'h04, 0, 0, 1, 8'h81, 8'h01, 0, 8); // R8 event beats clear
    step(6'h04, 0, 0, 0, 8'h00, 8'h00, 1, 8); // R8 empties one edge later
    step(6'h04, 0, 0, 1, 8'h00, 8'h00, 1, 7); // R7 re-enable all
    step(6'h06, 0, 0, 0, 8'h00, 8'h02, 1, 7); // R7 bit1 fires again
    step(6'h06, 0, 0, 0, 8'h00, 8'h02, 0, 4); // R4
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule